// File: doc/BRIEF.md
# Cache Throttling Hysteresis Controller

This block lowers the power drawn by a cache in measured steps when a power monitor reports that the chip runs too hot. At the end of every observation interval it receives the power measured over that interval and the allowed power. It then moves one position along an ordered throttle ladder. The first positions halve the number of loads and stores the processor may have outstanding. Once both limits are down to one, the later positions add hit latency one cycle at a time.

When power drops clearly below the limit, the ladder is walked back in reverse order. A dead band between ninety and one hundred percent of the limit keeps the settings steady, so they do not oscillate.

The settings act on the cache in two ways. Two masks mark pending-request buffer entries as unavailable, one mask for loads and one for stores. A delay line on the hit data return path adds the configured number of cycles to every returning hit. It keeps the hits in order and keeps back-to-back hits intact.

Top module: `cache_throttle_ctrl`

## Requirements
- R1: After reset the block allows 8 outstanding loads and 8 outstanding stores, adds zero extra latency, and marks no buffer entry unavailable (both masks all zero).
- R2: The settings change only in the cycle that follows a clock edge at which `ivl_end` is high. Power inputs seen without `ivl_end` have no effect.
- R3: At an interval end with `pwr_meas > pwr_limit`, if the allowed count is above 1, both the load count and the store count are halved, and the extra latency stays 0.
- R4: At an interval end with `pwr_meas > pwr_limit`, if both counts are already 1, the extra latency rises by one cycle. It saturates at 7.
- R5: At an interval end with `10*pwr_meas < 9*pwr_limit`, a nonzero extra latency falls by one. Otherwise both counts double, up to a maximum of 8.
- R6: At an interval end where power is neither over the limit nor under the 90 percent threshold, all settings hold. This band includes power exactly at the limit and power exactly at 90 percent of it.
- R7: Bit i of `ld_mask` and of `st_mask` is 1 (entry unavailable) exactly when i is greater than or equal to the allowed count. The lowest-numbered entries therefore stay usable.
- R8: With zero extra latency, `hit_valid_out` and `hit_data_out` follow `hit_valid_in` and `hit_data_in` in the same cycle.
- R9: With extra latency N, each hit presented on the input appears on the output exactly N cycles later, with the same data and in the same order. Back-to-back hits are neither lost nor merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ivl_end | input | 1 | Strobe marking the end of a power observation interval |
| pwr_meas | input | 16 | Power measured over the finished interval |
| pwr_limit | input | 16 | Allowed sustained power |
| ld_allow | output | 4 | Allowed outstanding loads |
| st_allow | output | 4 | Allowed outstanding stores |
| extra_lat | output | 3 | Extra hit latency in cycles |
| ld_mask | output | 8 | Load buffer entries marked unavailable |
| st_mask | output | 8 | Store buffer entries marked unavailable |
| hit_valid_in | input | 1 | Hit return valid from the cache |
| hit_data_in | input | 16 | Hit return data from the cache |
| hit_valid_out | output | 1 | Delayed hit return valid to the processor |
| hit_data_out | output | 16 | Delayed hit return data to the processor |

## Verification
A wrong ladder position shows up at the ports one cycle after the interval end that caused it. It appears as a count that was not halved or doubled, as latency that arrives before the counts reach one, or as a mask whose population disagrees with the count. It then persists until a later interval end. Errors in the dead band's edges show up only for power values exactly at the limit or exactly at ninety percent of it, so the sweeps cover those values. A delay line fault shows up as a hit arriving one cycle early or late, or as a hit dropped inside a burst. This is visible on the first hit after the latency changes.

// File: rtl/cthr_pkg.sv
package cthr_pkg;
  // Outcome of comparing one interval's power against the limit.
  typedef enum logic [1:0] {
    PWR_HOLD  = 2'd0,
    PWR_RAISE = 2'd1,  // over limit: throttle one step harder
    PWR_RELAX = 2'd2   // under 90 percent: undo one step
  } pwr_verdict_e;
endpackage

// File: rtl/power_compare.sv
module power_compare
  import cthr_pkg::*;
#(
  parameter int PWR_W = 16
) (
  input  logic [PWR_W-1:0] pwr_meas,
  input  logic [PWR_W-1:0] pwr_limit,
  output pwr_verdict_e     verdict
);
  localparam int EW = PWR_W + 4;

  logic [EW-1:0] meas_x10;
  logic [EW-1:0] limit_x9;

  // 10*m and 9*l through shifts, no divider needed
  assign meas_x10 = ({4'b0, pwr_meas} << 3) + ({4'b0, pwr_meas} << 1);
  assign limit_x9 = ({4'b0, pwr_limit} << 3) + {4'b0, pwr_limit};

  always_comb begin
    if (pwr_meas > pwr_limit)      verdict = PWR_RAISE;
    else if (meas_x10 < limit_x9)  verdict = PWR_RELAX;
    else                           verdict = PWR_HOLD;
  end
endmodule

// File: rtl/throttle_ladder.sv
module throttle_ladder
  import cthr_pkg::*;
#(
  parameter int MAX_OUTST = 8,
  parameter int LAT_MAX   = 7,
  localparam int NHALVE   = $clog2(MAX_OUTST),
  localparam int TOP      = NHALVE + LAT_MAX,
  localparam int SW       = $clog2(TOP + 1),
  localparam int CW       = $clog2(MAX_OUTST + 1),
  localparam int LW       = $clog2(LAT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  pwr_verdict_e  verdict,
  output logic [CW-1:0] allow,
  output logic [LW-1:0] lat
);
  logic [SW-1:0] step_q;
  logic [SW-1:0] step_d;

  // next-state
  always_comb begin
    step_d = step_q;
    case (verdict)
      PWR_RAISE: if (step_q != SW'(TOP)) step_d = step_q + SW'(1);
      PWR_RELAX: if (step_q != '0)       step_d = step_q - SW'(1);
      default:   step_d = step_q;
    endcase
  end

  // register with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  // decode ladder position into settings
  always_comb begin
    if (step_q <= SW'(NHALVE)) begin
      allow = CW'(MAX_OUTST) >> step_q;
      lat   = '0;
    end else begin
      allow = CW'(1);
      lat   = LW'(step_q - SW'(NHALVE));
    end
  end
endmodule

// File: rtl/entry_mask.sv
module entry_mask #(
  parameter int ENTRIES = 8,
  localparam int CW     = $clog2(ENTRIES + 1)
) (
  input  logic [CW-1:0]      allow,
  output logic [ENTRIES-1:0] unavail
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign unavail[i] = (CW'(i) >= allow);
  end
endmodule

// File: rtl/return_delay.sv
module return_delay #(
  parameter int DATA_W  = 16,
  parameter int LAT_MAX = 7,
  localparam int LW     = $clog2(LAT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LW-1:0]     lat,
  input  logic              vin,
  input  logic [DATA_W-1:0] din,
  output logic              vout,
  output logic [DATA_W-1:0] dout
);
  logic [LAT_MAX-1:0] vpipe;
  logic [DATA_W-1:0]  dpipe [LAT_MAX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < LAT_MAX; k++) begin
        vpipe[k] <= 1'b0;
        dpipe[k] <= '0;
      end
    end else begin
      vpipe[0] <= vin;
      dpipe[0] <= din;
      for (int k = 1; k < LAT_MAX; k++) begin
        vpipe[k] <= vpipe[k-1];
        dpipe[k] <= dpipe[k-1];
      end
    end
  end

  // tap select: 0 is a combinational bypass
  always_comb begin
    vout = vin;
    dout = din;
    for (int k = 0; k < LAT_MAX; k++) begin
      if (lat == LW'(k + 1)) begin
        vout = vpipe[k];
        dout = dpipe[k];
      end
    end
  end
endmodule

// File: rtl/cache_throttle_ctrl.sv
module cache_throttle_ctrl
  import cthr_pkg::*;
#(
  parameter int PWR_W     = 16,
  parameter int MAX_OUTST = 8,
  parameter int LAT_MAX   = 7,
  parameter int DATA_W    = 16,
  localparam int CW       = $clog2(MAX_OUTST + 1),
  localparam int LW       = $clog2(LAT_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ivl_end,
  input  logic [PWR_W-1:0]     pwr_meas,
  input  logic [PWR_W-1:0]     pwr_limit,
  output logic [CW-1:0]        ld_allow,
  output logic [CW-1:0]        st_allow,
  output logic [LW-1:0]        extra_lat,
  output logic [MAX_OUTST-1:0] ld_mask,
  output logic [MAX_OUTST-1:0] st_mask,
  input  logic                 hit_valid_in,
  input  logic [DATA_W-1:0]    hit_data_in,
  output logic                 hit_valid_out,
  output logic [DATA_W-1:0]    hit_data_out
);
  pwr_verdict_e  verdict;
  logic [CW-1:0] allow;
  logic [LW-1:0] lat;

  power_compare #(.PWR_W(PWR_W)) u_cmp (
    .pwr_meas (pwr_meas),
    .pwr_limit(pwr_limit),
    .verdict  (verdict)
  );

  throttle_ladder #(.MAX_OUTST(MAX_OUTST), .LAT_MAX(LAT_MAX)) u_ladder (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_en(ivl_end),
    .verdict(verdict),
    .allow  (allow),
    .lat    (lat)
  );

  entry_mask #(.ENTRIES(MAX_OUTST)) u_ld_mask (.allow(allow), .unavail(ld_mask));
  entry_mask #(.ENTRIES(MAX_OUTST)) u_st_mask (.allow(allow), .unavail(st_mask));

  return_delay #(.DATA_W(DATA_W), .LAT_MAX(LAT_MAX)) u_delay (
    .clk  (clk),
    .rst_n(rst_n),
    .lat  (lat),
    .vin  (hit_valid_in),
    .din  (hit_data_in),
    .vout (hit_valid_out),
    .dout (hit_data_out)
  );

  assign ld_allow  = allow;
  assign st_allow  = allow;
  assign extra_lat = lat;
endmodule

// File: rtl/cthr_checker.sv
module cthr_checker #(
  parameter int PWR_W     = 16,
  parameter int MAX_OUTST = 8,
  parameter int LAT_MAX   = 7,
  parameter int DATA_W    = 16,
  localparam int CW       = $clog2(MAX_OUTST + 1),
  localparam int LW       = $clog2(LAT_MAX + 1),
  localparam int EW       = PWR_W + 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ivl_end,
  input logic [PWR_W-1:0]     pwr_meas,
  input logic [PWR_W-1:0]     pwr_limit,
  input logic [CW-1:0]        ld_allow,
  input logic [CW-1:0]        st_allow,
  input logic [LW-1:0]        extra_lat,
  input logic [MAX_OUTST-1:0] ld_mask,
  input logic [MAX_OUTST-1:0] st_mask,
  input logic                 hit_valid_in,
  input logic [DATA_W-1:0]    hit_data_in,
  input logic                 hit_valid_out,
  input logic [DATA_W-1:0]    hit_data_out
);
  logic over_c, under_c;
  logic [EW-1:0] m10, l9;
  assign m10     = EW'(pwr_meas) * EW'(10);
  assign l9      = EW'(pwr_limit) * EW'(9);
  assign over_c  = pwr_meas > pwr_limit;
  assign under_c = !over_c && (m10 < l9);

  a_r2_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
    !ivl_end |=> $stable(ld_allow) && $stable(st_allow) && $stable(extra_lat));

  a_r3_halve: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_end && over_c && ld_allow > CW'(1)
      |=> ld_allow == ($past(ld_allow) >> 1) && st_allow == ld_allow && extra_lat == '0);

  a_r4_lat_up: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_end && over_c && ld_allow == CW'(1) && extra_lat < LW'(LAT_MAX)
      |=> extra_lat == LW'($past(extra_lat) + LW'(1)));

  a_r4_lat_only_at_one: assert property (@(posedge clk) disable iff (!rst_n)
    extra_lat != '0 |-> ld_allow == CW'(1) && st_allow == CW'(1));

  a_r5_lat_down: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_end && under_c && extra_lat != '0
      |=> extra_lat == LW'($past(extra_lat) - LW'(1)) && ld_allow == CW'(1));

  a_r6_hold_band: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_end && !over_c && !under_c |=> $stable(ld_allow) && $stable(extra_lat));

  a_r7_mask_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ld_mask) == MAX_OUTST - int'(ld_allow) &&
    $countones(st_mask) == MAX_OUTST - int'(st_allow));

  a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    extra_lat == '0 |-> hit_valid_out == hit_valid_in &&
                        (!hit_valid_in || hit_data_out == hit_data_in));

  a_r9_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
    extra_lat == LW'(1) && $past(extra_lat) == LW'(1)
      |-> hit_valid_out == $past(hit_valid_in) &&
          (!hit_valid_out || hit_data_out == $past(hit_data_in)));
endmodule

bind cache_throttle_ctrl cthr_checker #(
  .PWR_W(PWR_W), .MAX_OUTST(MAX_OUTST), .LAT_MAX(LAT_MAX), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ivl_end(ivl_end), .pwr_meas(pwr_meas),
  .pwr_limit(pwr_limit), .ld_allow(ld_allow), .st_allow(st_allow),
  .extra_lat(extra_lat), .ld_mask(ld_mask), .st_mask(st_mask),
  .hit_valid_in(hit_valid_in), .hit_data_in(hit_data_in),
  .hit_valid_out(hit_valid_out), .hit_data_out(hit_data_out)
);

// File: tb/sim_cache_throttle_ctrl.sv
`timescale 1ns/1ps
module sim_cache_throttle_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ivl_end = 1'b0;
  logic [15:0] pwr_meas = '0;
  logic [15:0] pwr_limit = '0;
  logic [3:0]  ld_allow, st_allow;
  logic [2:0]  extra_lat;
  logic [7:0]  ld_mask, st_mask;
  logic        hit_valid_in = 1'b0;
  logic [15:0] hit_data_in = '0;
  logic        hit_valid_out;
  logic [15:0] hit_data_out;

  int n_chk = 0;
  int n_err = 0;
  int ms = 0;  // model ladder position 0..10

  always #2.5 clk = ~clk;

  cache_throttle_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ivl_end(ivl_end), .pwr_meas(pwr_meas),
    .pwr_limit(pwr_limit), .ld_allow(ld_allow), .st_allow(st_allow),
    .extra_lat(extra_lat), .ld_mask(ld_mask), .st_mask(st_mask),
    .hit_valid_in(hit_valid_in), .hit_data_in(hit_data_in),
    .hit_valid_out(hit_valid_out), .hit_data_out(hit_data_out)
  );

  function automatic int m_allow();
    return (ms <= 3) ? (8 >> ms) : 1;
  endfunction
  function automatic int m_lat();
    return (ms > 3) ? ms - 3 : 0;
  endfunction
  function automatic int m_mask();
    return (~((1 << m_allow()) - 1)) & 8'hFF;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_settings(string req);
    chk(req, int'(ld_allow), m_allow());
    chk(req, int'(st_allow), m_allow());
    chk(req, int'(extra_lat), m_lat());
    chk({req, " R7 ld_mask"}, int'(ld_mask), m_mask());
    chk({req, " R7 st_mask"}, int'(st_mask), m_mask());
  endtask

  task automatic interval(int meas, int lim);
    string tag;
    @(negedge clk);
    pwr_meas = 16'(meas);
    pwr_limit = 16'(lim);
    ivl_end = 1'b1;
    if (meas > lim) begin
      tag = (ms < 3) ? "R3" : "R4";
      if (ms < 10) ms++;
    end else if (10 * meas < 9 * lim) begin
      tag = "R5";
      if (ms > 0) ms--;
    end else begin
      tag = "R6";
    end
    @(negedge clk);
    ivl_end = 1'b0;
    check_settings(tag);
  endtask

  // R2: power far over limit without the strobe changes nothing
  task automatic quiet_check(int cycles);
    pwr_meas = 16'd60000;
    pwr_limit = 16'd10;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      check_settings("R2");
    end
  endtask

  task automatic idle(int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      hit_valid_in = 1'b0;
      hit_data_in = '0;
    end
  endtask

  // R8 / R9: stream hits with bursts and gaps, compare N cycles later
  task automatic stream(int n);
    int hv[128];
    int hd[128];
    int lat;
    int ev;
    string tag;
    lat = m_lat();
    tag = (lat == 0) ? "R8" : "R9";
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      hv[t] = ((t % 5) != 3) ? 1 : 0;
      hd[t] = (t * 37 + lat * 1000 + 5) & 16'hFFFF;
      hit_valid_in = hv[t][0];
      hit_data_in = 16'(hd[t]);
      #1;
      ev = (t >= lat) ? hv[t - lat] : 0;
      chk({tag, " valid"}, int'(hit_valid_out), ev);
      if (ev == 1) chk({tag, " data"}, int'(hit_data_out), hd[t - lat]);
    end
    idle(9);
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_settings("R1");
    chk("R1 mask zero", int'(ld_mask | st_mask), 0);
    stream(30);

    // climb the whole ladder, stream at each position, overshoot to saturate
    for (int s = 0; s < 12; s++) begin
      interval(1001, 1000);
      quiet_check(2);
      if (s < 10) stream(30);
    end

    // dead band edges
    interval(1000, 1000);
    interval(900, 1000);
    interval(950, 1000);
    interval(0, 0);

    // walk back down, one step per interval
    for (int s = 0; s < 12; s++) begin
      interval(899, 1000);
      quiet_check(2);
      if (s < 10) stream(20);
    end

    // exhaustive sweep of measured power against small limits
    for (int rep = 0; rep < 3; rep++) begin
      for (int lim = 0; lim <= 21; lim += 7) begin
        for (int m = 0; m <= lim + 3; m++) interval(m, lim);
        for (int m = lim + 3; m >= 0; m--) interval(m, lim);
        for (int k = 0; k < 6; k++) interval(lim + 1, lim);
      end
    end

    // wide values exercise the x10 comparison near full scale
    interval(65535, 65534);
    interval(58981, 65535);
    interval(58982, 65535);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule